// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer with Page Protection

This block sits between a processor and a physically addressed cache. It holds a small set of translations, each from a virtual page number to a physical page number. A lookup compares the virtual page number against every stored tag at once. One clock edge later it reports one of four outcomes:

- a translated physical address;
- a miss;
- a page fault, when the matching page is marked not present;
- a protection fault, when the access kind breaks the page's permissions.

Software or a page-table walker loads translations through a refill port. Each refill goes to the slot named by a rotating pointer. A single invalidate input empties the whole buffer in one cycle.

Each entry stores four things: a virtual tag, a physical page number, a present bit, and two permission marks. One mark makes the page read-only and the other makes it execute-only. Different virtual pages may point to the same physical page. If several occupied entries carry the same tag, the one with the lowest index is used.

Top module: `xlat_buffer`

## Requirements
- R1: A lookup presented with `lk_valid` high produces its result with `rs_valid` high exactly one clock edge later. `rs_valid` is low in any cycle after a cycle without a lookup.
- R2: A lookup hits when an occupied entry's tag equals the upper `VPN_W` bits of `lk_vaddr`, the entry is present, and the access is allowed. `rs_paddr` is then the entry's physical page number above the low `OFF_W` bits of `lk_vaddr`, which pass through unchanged.
- R3: When more than one occupied entry carries the looked-up tag, the entry with the lowest index supplies the outcome and the physical page number.
- R4: When no occupied entry matches, `rs_miss` is set. For every outcome other than a hit, `rs_paddr` is zero.
- R5: With `rs_valid` high, exactly one of `rs_hit`, `rs_miss`, `rs_page_fault` and `rs_prot_fault` is set. With `rs_valid` low, all four are low.
- R6: A match on an entry whose present bit is clear raises `rs_page_fault`. This takes priority over any permission check.
- R7: The access kind `lk_kind` is encoded as 2'b00 load, 2'b01 store and 2'b10 fetch. A store to a read-only or execute-only page raises `rs_prot_fault`, and so does a load from an execute-only page. A load from a read-only page is allowed, and a fetch is allowed on every page.
- R8: Reset leaves every entry empty. A cycle with `inv_all` high empties every entry, so any lookup after it misses until new refills arrive.
- R9: Refills fill slots in rotating order. The order starts at slot 0 after reset, advances by one per accepted refill, and wraps from `ENTRIES-1` to 0, overwriting the older translation held there.
- R10: A refill in the same cycle as `inv_all` is dropped, and the rotating pointer keeps its value.
- R11: Two entries may hold the same physical page number for different virtual pages. Both translate correctly.
- R12: A lookup in the same cycle as a refill sees the buffer contents from before that refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VPN_W+OFF_W | Virtual address to translate |
| lk_kind | input | 2 | Access kind: 00 load, 01 store, 10 fetch |
| rf_valid | input | 1 | Refill request |
| rf_vpn | input | VPN_W | Virtual page number to install |
| rf_ppn | input | PPN_W | Physical page number to install |
| rf_present | input | 1 | Page is resident in memory |
| rf_ro | input | 1 | Page is read-only |
| rf_xo | input | 1 | Page is execute-only |
| inv_all | input | 1 | Empty every entry |
| rs_valid | output | 1 | Result valid |
| rs_paddr | output | PPN_W+OFF_W | Physical address, zero unless hit |
| rs_hit | output | 1 | Translation succeeded |
| rs_miss | output | 1 | No matching entry |
| rs_page_fault | output | 1 | Matching page not present |
| rs_prot_fault | output | 1 | Access breaks page permissions |

## Verification
The bench builds the buffer with 8 entries and 8-bit page numbers over a 4-bit offset. With so few slots, a short run can wrap the rotating pointer more than once, overwrite slot 0, and test pointer hold across an invalidate. The check for R10 places duplicate tags on both sides of the wrap point. The pointer's value after the invalidate then decides which duplicate wins the lowest-index rule, so a pointer that moves on the invalidate cycle shows up at the result port.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10
  } acc_kind_e;

  // Permission rule: stores need a writable data page, loads need a data page.
  function automatic logic perm_denied(input logic ro, input logic xo,
                                       input logic [1:0] kind);
    logic deny;
    deny = 1'b0;
    if (kind == ACC_STORE) deny = ro | xo;
    else if (kind == ACC_LOAD) deny = xo;
    return deny;
  endfunction

  // Rotating slot pointer step with wrap at count-1.
  function automatic int unsigned ring_next(input int unsigned cur,
                                            input int unsigned count);
    return (cur + 1 >= count) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/xlat_store.sv
module xlat_store
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inv_all,
  input  logic             rf_valid,
  input  logic [VPN_W-1:0] rf_vpn,
  input  logic [PPN_W-1:0] rf_ppn,
  input  logic             rf_present,
  input  logic             rf_ro,
  input  logic             rf_xo,
  output logic [VPN_W-1:0] tag_arr   [ENTRIES],
  output logic [PPN_W-1:0] frame_arr [ENTRIES],
  output logic [ENTRIES-1:0] used_vec,
  output logic [ENTRIES-1:0] present_vec,
  output logic [ENTRIES-1:0] ro_vec,
  output logic [ENTRIES-1:0] xo_vec,
  output logic [IDX_W-1:0]   wr_ptr
);

  logic accept;
  assign accept = rf_valid && !inv_all;

  always_ff @(posedge clk) begin
    if (rst) wr_ptr <= '0;
    else if (accept) wr_ptr <= IDX_W'(ring_next(32'(wr_ptr), ENTRIES));
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    logic sel;
    assign sel = accept && (wr_ptr == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst || inv_all) begin
        used_vec[i] <= 1'b0;
      end else if (sel) begin
        used_vec[i] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        tag_arr[i]     <= '0;
        frame_arr[i]   <= '0;
        present_vec[i] <= 1'b0;
        ro_vec[i]      <= 1'b0;
        xo_vec[i]      <= 1'b0;
      end else if (sel) begin
        tag_arr[i]     <= rf_vpn;
        frame_arr[i]   <= rf_ppn;
        present_vec[i] <= rf_present;
        ro_vec[i]      <= rf_ro;
        xo_vec[i]      <= rf_xo;
      end
    end
  end

endmodule

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [VPN_W-1:0]   tag_arr [ENTRIES],
  input  logic [ENTRIES-1:0] used_vec,
  input  logic [VPN_W-1:0]   look_vpn,
  output logic [ENTRIES-1:0] match_vec,
  output logic               any_match,
  output logic [IDX_W-1:0]   win_idx
);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match_vec[i] = used_vec[i] && (tag_arr[i] == look_vpn);
  end

  // Scan from the top so the lowest matching index is the one left standing.
  always_comb begin
    win_idx   = '0;
    any_match = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_vec[i]) begin
        win_idx   = IDX_W'(i);
        any_match = 1'b1;
      end
    end
  end

endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int OFF_W   = 12,
  localparam int VA_W   = VPN_W + OFF_W,
  localparam int PA_W   = PPN_W + OFF_W,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic [1:0]       lk_kind,
  input  logic             rf_valid,
  input  logic [VPN_W-1:0] rf_vpn,
  input  logic [PPN_W-1:0] rf_ppn,
  input  logic             rf_present,
  input  logic             rf_ro,
  input  logic             rf_xo,
  input  logic             inv_all,
  output logic             rs_valid,
  output logic [PA_W-1:0]  rs_paddr,
  output logic             rs_hit,
  output logic             rs_miss,
  output logic             rs_page_fault,
  output logic             rs_prot_fault
);

  logic [VPN_W-1:0]   tag_arr   [ENTRIES];
  logic [PPN_W-1:0]   frame_arr [ENTRIES];
  logic [ENTRIES-1:0] used_vec, present_vec, ro_vec, xo_vec;
  logic [IDX_W-1:0]   wr_ptr;
  logic [ENTRIES-1:0] match_vec;
  logic               any_match;
  logic [IDX_W-1:0]   win_idx;

  xlat_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_store (
    .clk(clk), .rst(rst), .inv_all(inv_all),
    .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_ppn(rf_ppn),
    .rf_present(rf_present), .rf_ro(rf_ro), .rf_xo(rf_xo),
    .tag_arr(tag_arr), .frame_arr(frame_arr), .used_vec(used_vec),
    .present_vec(present_vec), .ro_vec(ro_vec), .xo_vec(xo_vec),
    .wr_ptr(wr_ptr)
  );

  logic [VPN_W-1:0] look_vpn;
  logic [OFF_W-1:0] look_off;
  assign look_vpn = lk_vaddr[VA_W-1:OFF_W];
  assign look_off = lk_vaddr[OFF_W-1:0];

  xlat_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_match (
    .tag_arr(tag_arr), .used_vec(used_vec), .look_vpn(look_vpn),
    .match_vec(match_vec), .any_match(any_match), .win_idx(win_idx)
  );

  // Named classification events of the winning entry.
  logic win_present, win_denied;
  logic ev_hit, ev_miss, ev_page_fault, ev_prot_fault;
  logic [PA_W-1:0] ev_paddr;

  assign win_present   = present_vec[win_idx];
  assign win_denied    = perm_denied(ro_vec[win_idx], xo_vec[win_idx], lk_kind);
  assign ev_miss       = !any_match;
  assign ev_page_fault = any_match && !win_present;
  assign ev_prot_fault = any_match && win_present && win_denied;
  assign ev_hit        = any_match && win_present && !win_denied;
  assign ev_paddr      = ev_hit ? {frame_arr[win_idx], look_off} : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      rs_valid      <= 1'b0;
      rs_paddr      <= '0;
      rs_hit        <= 1'b0;
      rs_miss       <= 1'b0;
      rs_page_fault <= 1'b0;
      rs_prot_fault <= 1'b0;
    end else begin
      rs_valid      <= lk_valid;
      rs_paddr      <= lk_valid ? ev_paddr : '0;
      rs_hit        <= lk_valid && ev_hit;
      rs_miss       <= lk_valid && ev_miss;
      rs_page_fault <= lk_valid && ev_page_fault;
      rs_prot_fault <= lk_valid && ev_prot_fault;
    end
  end

endmodule

// File: rtl/xlat_checker.sv
module xlat_checker
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int PA_W    = 32,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input logic               clk,
  input logic               rst,
  input logic               lk_valid,
  input logic               rf_valid,
  input logic               inv_all,
  input logic               rs_valid,
  input logic [PA_W-1:0]    rs_paddr,
  input logic               rs_hit,
  input logic               rs_miss,
  input logic               rs_page_fault,
  input logic               rs_prot_fault,
  input logic [ENTRIES-1:0] used_vec,
  input logic [IDX_W-1:0]   wr_ptr
);

  assert_result_follows_R1: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rs_valid);
  assert_no_spurious_R1: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rs_valid);
  assert_one_outcome_R5: assert property (@(posedge clk) disable iff (rst)
    rs_valid |-> $countones({rs_hit, rs_miss, rs_page_fault, rs_prot_fault}) == 1);
  assert_quiet_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !rs_valid |-> !(rs_hit || rs_miss || rs_page_fault || rs_prot_fault));
  assert_paddr_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (rs_valid && !rs_hit) |-> rs_paddr == '0);
  assert_flush_empty_R8: assert property (@(posedge clk) disable iff (rst)
    inv_all |=> used_vec == '0);
  assert_ptr_step_R9: assert property (@(posedge clk) disable iff (rst)
    (rf_valid && !inv_all) |=> wr_ptr == IDX_W'(ring_next(32'($past(wr_ptr)), ENTRIES)));
  assert_ptr_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (inv_all || !rf_valid) |=> $stable(wr_ptr));

endmodule

bind xlat_buffer xlat_checker #(.ENTRIES(ENTRIES), .PA_W(PA_W)) u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .rf_valid(rf_valid),
  .inv_all(inv_all), .rs_valid(rs_valid), .rs_paddr(rs_paddr),
  .rs_hit(rs_hit), .rs_miss(rs_miss), .rs_page_fault(rs_page_fault),
  .rs_prot_fault(rs_prot_fault), .used_vec(used_vec), .wr_ptr(wr_ptr)
);

// File: tb/tb_xlat_buffer.sv
`timescale 1ns/1ps
module tb_xlat_buffer;
  localparam int E = 8, VW = 8, PW = 8, OW = 4;
  localparam int VAW = VW + OW, PAW = PW + OW;

  logic clk = 0, rst = 1;
  always #2 clk = ~clk;

  logic lk_valid = 0, rf_valid = 0, rf_present = 0, rf_ro = 0, rf_xo = 0, inv_all = 0;
  logic [VAW-1:0] lk_vaddr = '0;
  logic [1:0] lk_kind = '0;
  logic [VW-1:0] rf_vpn = '0;
  logic [PW-1:0] rf_ppn = '0;
  logic rs_valid, rs_hit, rs_miss, rs_page_fault, rs_prot_fault;
  logic [PAW-1:0] rs_paddr;

  xlat_buffer #(.ENTRIES(E), .VPN_W(VW), .PPN_W(PW), .OFF_W(OW)) dut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_kind(lk_kind),
    .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_ppn(rf_ppn), .rf_present(rf_present),
    .rf_ro(rf_ro), .rf_xo(rf_xo), .inv_all(inv_all), .rs_valid(rs_valid),
    .rs_paddr(rs_paddr), .rs_hit(rs_hit), .rs_miss(rs_miss),
    .rs_page_fault(rs_page_fault), .rs_prot_fault(rs_prot_fault));

  int checks = 0, failures = 0;
  bit finished = 0;

  typedef struct {
    logic [3:0] flags;   // {hit, miss, page fault, prot fault}
    logic [PAW-1:0] paddr;
    string req;
  } exp_t;
  exp_t sb[$];

  // Reference model of the buffer contents.
  bit m_used[E]; bit m_pres[E]; bit m_ro[E]; bit m_xo[E];
  logic [VW-1:0] m_vpn[E]; logic [PW-1:0] m_ppn[E];
  int m_ptr = 0;

  function automatic exp_t predict(logic [VAW-1:0] va, logic [1:0] kind, string req);
    exp_t e;
    e.req = req; e.flags = 4'b0100; e.paddr = '0;
    for (int i = 0; i < E; i++) begin
      if (m_used[i] && m_vpn[i] == va[VAW-1:OW]) begin
        if (!m_pres[i]) e.flags = 4'b0010;
        else if ((kind == 2'b01 && (m_ro[i] || m_xo[i])) || (kind == 2'b00 && m_xo[i]))
          e.flags = 4'b0001;
        else begin
          e.flags = 4'b1000;
          e.paddr = {m_ppn[i], va[OW-1:0]};
        end
        return e;
      end
    end
    return e;
  endfunction

  task automatic step(input bit dl, input logic [VAW-1:0] va, input logic [1:0] kind,
                      input bit dr, input logic [VW-1:0] vpn, input logic [PW-1:0] ppn,
                      input bit p, input bit ro, input bit xo, input bit di, input string req);
    @(negedge clk);
    lk_valid = dl; lk_vaddr = va; lk_kind = kind;
    rf_valid = dr; rf_vpn = vpn; rf_ppn = ppn; rf_present = p; rf_ro = ro; rf_xo = xo;
    inv_all = di;
    if (dl) sb.push_back(predict(va, kind, req));
    if (di) begin
      for (int i = 0; i < E; i++) m_used[i] = 0;
    end else if (dr) begin
      m_used[m_ptr] = 1; m_vpn[m_ptr] = vpn; m_ppn[m_ptr] = ppn;
      m_pres[m_ptr] = p; m_ro[m_ptr] = ro; m_xo[m_ptr] = xo;
      m_ptr = (m_ptr == E - 1) ? 0 : m_ptr + 1;
    end
  endtask

  task automatic look(input logic [VAW-1:0] va, input logic [1:0] kind, input string req);
    step(1, va, kind, 0, '0, '0, 0, 0, 0, 0, req);
  endtask

  task automatic fill(input logic [VW-1:0] vpn, input logic [PW-1:0] ppn,
                      input bit p, input bit ro, input bit xo);
    step(0, '0, 2'b00, 1, vpn, ppn, p, ro, xo, 0, "");
  endtask

  // Monitor: compares each result against the queue head.
  always @(negedge clk) begin
    if (!rst && rs_valid) begin
      exp_t e;
      checks++;
      if (sb.size() == 0) begin
        failures++;
        $display("FAIL R1: unexpected result flags=%b expected no result",
                 {rs_hit, rs_miss, rs_page_fault, rs_prot_fault});
      end else begin
        e = sb.pop_front();
        if ({rs_hit, rs_miss, rs_page_fault, rs_prot_fault} !== e.flags || rs_paddr !== e.paddr) begin
          failures++;
          $display("FAIL %s: flags=%b paddr=%h expected flags=%b paddr=%h",
                   e.req, {rs_hit, rs_miss, rs_page_fault, rs_prot_fault}, rs_paddr,
                   e.flags, e.paddr);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < E; i++) m_used[i] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    checks++;
    if ({rs_valid, rs_hit, rs_miss, rs_page_fault, rs_prot_fault} !== 5'b0) begin
      failures++;
      $display("FAIL R8: reset outputs=%b expected 00000",
               {rs_valid, rs_hit, rs_miss, rs_page_fault, rs_prot_fault});
    end
    look(12'h123, 2'b00, "R8");                // empty after reset
    fill(8'h12, 8'hA5, 1, 0, 0);               // slot 0
    fill(8'h34, 8'hA5, 1, 1, 0);               // slot 1, same frame, read-only
    fill(8'h56, 8'h3C, 1, 0, 1);               // slot 2, execute-only
    fill(8'h78, 8'h11, 0, 1, 0);               // slot 3, not present
    fill(8'h12, 8'h99, 1, 0, 0);               // slot 4, duplicate tag
    look(12'h127, 2'b00, "R2");
    look(12'h12F, 2'b01, "R3");                // slot 0 wins over slot 4
    look(12'h34F, 2'b01, "R7");                // store to read-only
    look(12'h341, 2'b00, "R11");               // load read-only, shared frame
    look(12'h562, 2'b10, "R7");                // fetch execute-only
    look(12'h562, 2'b00, "R7");
    look(12'h562, 2'b01, "R7");
    look(12'h780, 2'b01, "R6");                // page fault beats protection
    look(12'h9A0, 2'b00, "R4");
    step(1, 12'hBB3, 2'b00, 1, 8'hBB, 8'h44, 1, 0, 0, 0, "R12"); // slot 5
    look(12'hBB3, 2'b00, "R12");
    fill(8'h61, 8'h01, 1, 0, 0);               // slot 6
    fill(8'h62, 8'h02, 1, 0, 0);               // slot 7
    fill(8'hC0, 8'h42, 1, 0, 0);               // wraps to slot 0
    look(12'h125, 2'b00, "R9");                // now slot 4 frame 99
    look(12'hC07, 2'b01, "R9");
    look(12'h620, 2'b10, "R9");
    step(0, '0, 2'b00, 1, 8'hF0, 8'h77, 1, 0, 0, 1, "R10"); // flush, refill dropped
    look(12'hF00, 2'b00, "R10");
    look(12'h620, 2'b00, "R8");
    look(12'hC00, 2'b00, "R8");
    for (int k = 0; k < 6; k++) fill(8'hD0 + 8'(k), 8'h10 + 8'(k), 1, 0, 0);
    fill(8'hE0, 8'h66, 1, 0, 0);
    fill(8'hE0, 8'h55, 1, 0, 0);
    look(12'hE09, 2'b00, "R10");               // pointer held decides winner
    look(12'hD3A, 2'b01, "R2");
    step(0, '0, 2'b00, 0, '0, '0, 0, 0, 0, 0, "");
    repeat (3) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      failures++;
      $display("FAIL R1: pending results=%0d expected 0", sb.size());
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule